// File: doc/BRIEF.md
# Token Bucket Flow Meter

This block polices a single traffic stream against a configured rate and burst. It holds a credit level measured in bytes. Each frame that arrives is judged in the cycle it arrives: if the stored credit covers the frame length, the frame conforms and its length is taken from the credit. If not, the frame is marked for dropping and the credit is left as it was. Credit does not leak in continuously. It is topped up in discrete refill events, and each refill tick adds a programmable token amount. The burst size caps the stored credit.

Frame arrivals use a valid/ready handshake. The meter takes one frame per cycle and never applies back-pressure once it is out of reset, so `frm_ready` is low only during reset and for the first cycle after it. A frame counts only in a cycle where both `frm_valid` and `frm_ready` are high. The verdict for that frame appears combinationally in the same cycle on `dec_valid`/`dec_pass`. No handshake applies to the verdict, and the consumer must take it in that cycle. The refill tick and the configuration fields are plain level inputs that are sampled every cycle.

A token amount of all ones (0x1FFF) is reserved and turns policing off. The largest token amount that meters normally is 0x1FFE.

Top module: `tbm_flow_meter`

## Requirements
- R1: While `rst_n` is low, the credit level is loaded with `cfg_burst` and `frm_ready` is 0. `frm_ready` reads 1 from the first cycle after reset is released, and the bucket starts full.
- R2: When `cfg_tokens` is 0x1FFF, every accepted frame gets `dec_pass`=1 whatever its length. Neither frames nor refill ticks change the credit level while this value is set.
- R3: A refill tick adds `cfg_tokens` to the credit, and the result saturates at `cfg_burst`. The credit never exceeds the burst value sampled at the previous edge, so lowering `cfg_burst` clamps the credit at the next edge.
- R4: An accepted frame conforms (`dec_pass`=1) exactly when the credit level is greater than or equal to `frm_len`. The equal case passes. The verdict is given in the arrival cycle.
- R5: A conforming frame subtracts `frm_len` from the credit. A dropped frame leaves the credit unchanged.
- R6: When a refill tick and a frame fall in the same cycle, the frame is judged against the credit held before that refill. The next level is min(level − debit + tokens, burst).
- R7: `dec_valid` equals `frm_valid` AND `frm_ready`. A frame offered while `frm_ready` is 0, or with `frm_valid` at 0, has no effect on the credit.
- R8: A token amount of 0x1FFE is a normal amount: one refill from an empty bucket gives a credit of exactly 8190 bytes when the burst allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | Frame arrival offered |
| frm_ready | output | 1 | Meter accepts a frame this cycle |
| frm_len | input | LEN_W (14) | Frame length in bytes |
| refill_tick | input | 1 | Refill event strobe |
| cfg_tokens | input | 13 | Bytes added per refill; 0x1FFF disables policing |
| cfg_burst | input | LVL_W (20) | Burst size, the cap on stored credit |
| dec_valid | output | 1 | Verdict present for the accepted frame |
| dec_pass | output | 1 | 1 = conform, 0 = drop |

## Verification
The case that needs the most care is a refill tick and a frame arrival in the same cycle. In that cycle the verdict must use the credit held before the refill, while the next level takes both the debit and the addition before saturation. The bench provokes this from an empty bucket, where a frame that the refill alone would cover must still be dropped. It also provokes it with a full bucket and an equal-length frame, where the debit and the refill must net out against the burst cap. A behavioural model is compared with the verdict and ready outputs on every cycle, and the later pass/drop outcomes of probe frames expose any wrong level update.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

  // Width of the per-refill token amount.
  localparam int unsigned TOK_W = 13;

  // Reserved token amount that switches metering off.
  localparam logic [TOK_W-1:0] TOK_BYPASS = '1;

  // Largest amount that still meters.
  localparam logic [TOK_W-1:0] TOK_LARGEST = TOK_BYPASS - 1'b1;

  // Verdict bundle presented on the arrival cycle.
  typedef struct packed {
    logic valid;
    logic pass;
  } verdict_t;

endpackage

// File: rtl/tbm_admit.sv
module tbm_admit (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);

  // Acceptance follows reset by one edge; no back-pressure afterwards.
  always_ff @(posedge clk) begin
    ready <= rst_n;
  end

endmodule

// File: rtl/tbm_conform.sv
module tbm_conform #(
  parameter int unsigned LEN_W = 14,
  parameter int unsigned LVL_W = 20
) (
  input  logic             take,
  input  logic             bypass,
  input  logic [LVL_W-1:0] level,
  input  logic [LEN_W-1:0] len,
  output logic             pass,
  output logic [LVL_W-1:0] debit
);

  localparam int unsigned CMP_W = (LVL_W > LEN_W) ? LVL_W : LEN_W;

  logic [CMP_W-1:0] lvl_ext;
  logic [CMP_W-1:0] len_ext;
  logic             covers;

  generate
    if (CMP_W > LVL_W) begin : g_pad_lvl
      assign lvl_ext = {{(CMP_W-LVL_W){1'b0}}, level};
    end else begin : g_keep_lvl
      assign lvl_ext = level;
    end
    if (CMP_W > LEN_W) begin : g_pad_len
      assign len_ext = {{(CMP_W-LEN_W){1'b0}}, len};
    end else begin : g_keep_len
      assign len_ext = len;
    end
  endgenerate

  // Credit covers the frame, equal case included.
  assign covers = (lvl_ext >= len_ext);

  always_comb begin
    pass  = 1'b0;
    debit = '0;
    if (take) begin
      if (bypass) begin
        pass = 1'b1;
      end else if (covers) begin
        pass  = 1'b1;
        debit = len_ext[LVL_W-1:0];
      end
    end
  end

endmodule

// File: rtl/tbm_bucket.sv
module tbm_bucket #(
  parameter int unsigned LVL_W = 20,
  parameter int unsigned TOK_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bypass,
  input  logic [TOK_W-1:0] tokens,
  input  logic [LVL_W-1:0] burst,
  input  logic [LVL_W-1:0] debit,
  output logic [LVL_W-1:0] level_q
);

  localparam int unsigned SUM_W = LVL_W + 1;

  logic [TOK_W-1:0] add;
  logic [SUM_W-1:0] after_debit;
  logic [SUM_W-1:0] after_add;
  logic [SUM_W-1:0] cap;
  logic [LVL_W-1:0] nxt;

  // Refill only while metering; bypass freezes the credit.
  assign add = (tick && !bypass) ? tokens : '0;

  assign after_debit = {1'b0, level_q} - {1'b0, debit};
  assign after_add   = after_debit + {{(SUM_W-TOK_W){1'b0}}, add};
  assign cap         = {1'b0, burst};

  // Saturate at the burst size.
  always_comb begin
    if (after_add > cap) begin
      nxt = burst;
    end else begin
      nxt = after_add[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q <= burst;
    end else begin
      level_q <= nxt;
    end
  end

endmodule

// File: rtl/tbm_flow_meter.sv
module tbm_flow_meter
  import tbm_pkg::*;
#(
  parameter int unsigned LEN_W = 14,
  parameter int unsigned LVL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_valid,
  output logic             frm_ready,
  input  logic [LEN_W-1:0] frm_len,
  input  logic             refill_tick,
  input  logic [TOK_W-1:0] cfg_tokens,
  input  logic [LVL_W-1:0] cfg_burst,
  output logic             dec_valid,
  output logic             dec_pass
);

  logic             ready;
  logic             take;
  logic             bypass;
  logic             pass;
  logic [LVL_W-1:0] debit;
  logic [LVL_W-1:0] level_q;
  verdict_t         verdict;

  assign bypass = (cfg_tokens == TOK_BYPASS);
  assign take   = frm_valid && ready;

  tbm_admit u_admit (
    .clk   (clk),
    .rst_n (rst_n),
    .ready (ready)
  );

  tbm_conform #(
    .LEN_W (LEN_W),
    .LVL_W (LVL_W)
  ) u_conform (
    .take   (take),
    .bypass (bypass),
    .level  (level_q),
    .len    (frm_len),
    .pass   (pass),
    .debit  (debit)
  );

  tbm_bucket #(
    .LVL_W (LVL_W),
    .TOK_W (TOK_W)
  ) u_bucket (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (refill_tick),
    .bypass  (bypass),
    .tokens  (cfg_tokens),
    .burst   (cfg_burst),
    .debit   (debit),
    .level_q (level_q)
  );

  assign verdict.valid = take;
  assign verdict.pass  = pass;

  assign frm_ready = ready;
  assign dec_valid = verdict.valid;
  assign dec_pass  = verdict.pass;

endmodule

// File: rtl/tbm_flow_meter_chk.sv
module tbm_flow_meter_chk #(
  parameter int unsigned LEN_W = 14,
  parameter int unsigned LVL_W = 20,
  parameter int unsigned TOK_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_ready,
  input logic             refill_tick,
  input logic [TOK_W-1:0] cfg_tokens,
  input logic [LVL_W-1:0] cfg_burst,
  input logic             dec_valid,
  input logic             dec_pass,
  input logic [LVL_W-1:0] level_q
);

  // R1: credit equals the burst in the first cycle out of reset.
  p_reset_full_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> level_q == $past(cfg_burst));

  // R2: bypass value passes every accepted frame.
  p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_tokens == '1) |-> dec_pass);

  // R3: credit never above the previously sampled burst.
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> level_q <= $past(cfg_burst));

  // R5: a dropped frame without refill leaves the credit alone.
  p_drop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_pass && !refill_tick && level_q <= cfg_burst)
      |=> level_q == $past(level_q));

  // R6: without a refill the credit can only stay or fall.
  p_no_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !refill_tick |=> level_q <= $past(level_q));

  // R7: no verdict while the meter refuses frames.
  p_ready_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_ready |-> !dec_valid);

endmodule

bind tbm_flow_meter tbm_flow_meter_chk #(
  .LEN_W (LEN_W),
  .LVL_W (LVL_W),
  .TOK_W (tbm_pkg::TOK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frm_ready   (frm_ready),
  .refill_tick (refill_tick),
  .cfg_tokens  (cfg_tokens),
  .cfg_burst   (cfg_burst),
  .dec_valid   (dec_valid),
  .dec_pass    (dec_pass),
  .level_q     (level_q)
);

// File: tb/sim_tbm_flow_meter.sv
`timescale 1ns/1ps
module sim_tbm_flow_meter;

  localparam int LEN_W = 14;
  localparam int LVL_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             frm_valid = 1'b0;
  logic             frm_ready;
  logic [LEN_W-1:0] frm_len = '0;
  logic             refill_tick = 1'b0;
  logic [12:0]      cfg_tokens = 13'd100;
  logic [LVL_W-1:0] cfg_burst = 20'd1000;
  logic             dec_valid;
  logic             dec_pass;

  int checks = 0;
  int errors = 0;
  longint m_level = 0;
  bit m_ready = 0;

  always #2.5 clk = ~clk;

  tbm_flow_meter #(.LEN_W(LEN_W), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .refill_tick(refill_tick), .cfg_tokens(cfg_tokens),
    .cfg_burst(cfg_burst), .dec_valid(dec_valid), .dec_pass(dec_pass)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare with the model, then advance the model at the edge.
  task automatic step(input bit v, input int len, input bit tk, input string tag);
    bit exp_dv;
    bit exp_pass;
    bit dis;
    longint nl;
    @(negedge clk);
    frm_valid = v;
    frm_len = len[LEN_W-1:0];
    refill_tick = tk;
    #1;
    dis = (cfg_tokens == 13'h1FFF);
    exp_dv = v && m_ready;
    exp_pass = exp_dv && (dis || m_level >= len);
    chk(tag, "frm_ready", int'(frm_ready), int'(m_ready));
    chk(tag, "dec_valid", int'(dec_valid), int'(exp_dv));
    if (exp_dv) chk(tag, "dec_pass", int'(dec_pass), int'(exp_pass));
    @(posedge clk);
    #1;
    nl = m_level;
    if (!dis) begin
      if (exp_pass) nl = nl - len;
      if (tk) nl = nl + cfg_tokens;
    end
    if (nl > cfg_burst) nl = cfg_burst;
    m_level = nl;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; frm_valid = 0; refill_tick = 0;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk("R1", "frm_ready in reset", int'(frm_ready), 0);
    end
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    m_ready = 1;
    m_level = cfg_burst;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1/R4: full bucket, equal length passes, then empty.
    step(1, 1000, 0, "R1");
    step(1, 1, 0, "R4");
    step(0, 0, 1, "R3");
    step(1, 101, 0, "R4");
    step(1, 100, 0, "R4");
    // R5: dropped frame keeps credit; probe afterwards.
    step(0, 0, 1, "R5");
    step(1, 150, 0, "R5");
    step(1, 100, 0, "R5");
    step(1, 1, 0, "R5");
    // R3: saturation at burst.
    repeat (20) step(0, 0, 1, "R3");
    step(1, 1001, 0, "R3");
    step(1, 1000, 0, "R3");
    step(1, 1, 0, "R3");
    // R6: tick and frame together from empty: judged pre-refill.
    step(1, 50, 1, "R6");
    step(1, 100, 1, "R6");
    step(1, 100, 0, "R6");
    step(1, 1, 0, "R6");
    // R6 at the cap: full bucket, frame equal to burst with refill.
    repeat (12) step(0, 0, 1, "R6");
    step(1, 1000, 1, "R6");
    step(1, 101, 0, "R6");
    step(1, 100, 0, "R6");
    // R2: bypass passes everything and freezes credit.
    cfg_tokens = 13'h1FFF;
    step(1, 16383, 0, "R2");
    step(1, 16383, 1, "R2");
    repeat (5) step(0, 0, 1, "R2");
    step(1, 5000, 0, "R2");
    cfg_tokens = 13'd100;
    step(1, 1, 0, "R2");
    // R8: largest normal amount.
    cfg_burst = 20'd20000;
    cfg_tokens = 13'h1FFE;
    step(0, 0, 1, "R8");
    step(1, 8191, 0, "R8");
    step(1, 8190, 0, "R8");
    step(1, 1, 0, "R8");
    // R3: lowering the burst clamps credit.
    repeat (4) step(0, 0, 1, "R3");
    cfg_burst = 20'd300;
    step(0, 0, 0, "R3");
    step(1, 301, 0, "R3");
    step(1, 300, 0, "R3");
    // R7: frames without valid do nothing.
    cfg_tokens = 13'd100;
    step(0, 0, 1, "R7");
    repeat (4) step(0, 100, 0, "R7");
    step(1, 101, 0, "R7");
    step(1, 100, 0, "R7");
    // R1: reset mid-run refills the bucket.
    cfg_burst = 20'd700;
    do_reset();
    step(1, 700, 0, "R1");
    // Mixed traffic against the model.
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 64) == 0) cfg_tokens = (($urandom % 8) == 0) ? 13'h1FFF : 13'($urandom % 400);
      if (($urandom % 128) == 0) cfg_burst = 20'(200 + $urandom % 3000);
      step(($urandom % 2) == 1, int'($urandom % 1600), ($urandom % 4) == 0, "R4");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule